// File: doc/BRIEF.md
# Parallel Port Register Interface

This block is the processor-facing register file of a three-port, byte-wide parallel peripheral. A host reaches it over an 8-bit data bus with a select, a read strobe, a write strobe and a two-bit register address. Three of the four addresses hold the data latches of ports A, B and C. The fourth address is a control location that accepts two kinds of command, and bit 7 of the written byte picks which one.

A command with bit 7 set is a configuration word. It sets the direction of port A, port B and each nibble of port C, and it sets the operating mode of the two port groups. The first group is port A with the upper nibble of port C. The second group is port B with the lower nibble of port C. A command with bit 7 clear sets or clears one bit of the port C latch and changes nothing else.

The block drives the output latches, one direction enable for each port or nibble, and the decoded group modes. The strobe and acknowledge sequencing logic next to this block reads those mode outputs. All bus transfers are synchronous to the clock.

Top module: `ppi_regif`

## Requirements
- R1: The address selects the target of a write: 00 is port A, 01 is port B, 10 is port C and 11 is the control location. A data write changes only the latch it addresses.
- R2: A synchronous active-low reset loads the configuration word 9BH. After reset all four direction enables are 0 (input), both group modes are 0, and all three output latches are 00H.
- R3: A control write with bit 7 = 1 stores a configuration word. Its fields are: bits 6:5 group A mode, bit 4 port A direction, bit 3 upper port C direction, bit 2 group B mode, bit 1 port B direction, bit 0 lower port C direction. A direction bit of 1 means input, so the drive enable is its inverse. 98H gives port A and upper C as inputs and port B and lower C as outputs. 92H gives ports A and B as inputs and all of port C as outputs.
- R4: The group A mode output `ga_mode` is 0 when field 6:5 is 00, 1 when it is 01, and 2 when it is 10 or 11. It never shows 3. The group B mode output `gb_mode` equals bit 2.
- R5: Writing a configuration word clears the port A, B and C output latches to 00H.
- R6: A control write with bit 7 = 0 changes port C bit N to the value of bit 0, where N is written in bits 3:1. Bits 6:4 have no effect. The other latch bits, the other latches, the directions and the modes stay as they were. For example, 0DH sets bit 6, 06H clears bit 3 and 71H sets bit 0.
- R7: A read of the control location returns the last configuration word. Set/reset commands do not change this value.
- R8: A read updates `bus_rdata` on the clock edge at which select and read are both high. Between reads `bus_rdata` holds its value. For each bit of a port (each nibble for port C), the read returns the output latch when that part drives, and otherwise returns the pin value sampled at that edge.
- R9: A data write to a port updates its latch even while the port is an input. The latch value is always present on that port's output bus.
- R10: While select is low, the write and read strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Block select, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pa_pins | input | 8 | Port A pin levels |
| pb_pins | input | 8 | Port B pin levels |
| pc_pins | input | 8 | Port C pin levels |
| pa_out | output | 8 | Port A output latch |
| pb_out | output | 8 | Port B output latch |
| pc_out | output | 8 | Port C output latch |
| pa_drive | output | 1 | Port A drives its pins |
| pb_drive | output | 1 | Port B drives its pins |
| pcu_drive | output | 1 | Port C bits 7:4 drive their pins |
| pcl_drive | output | 1 | Port C bits 3:0 drive their pins |
| ga_mode | output | 2 | Group A mode: 0, 1 or 2 |
| gb_mode | output | 1 | Group B mode: 0 or 1 |

## Verification
The bench sends set/reset commands with bits 6:4 set. A decoder that tested only bit 7 loosely, or took the bit index from the wrong field, would then touch the wrong port C bit or overwrite the configuration read back from the control location. It reads port C while one nibble is input and the other is output, which catches a read path that picks one source for the whole byte. It writes configuration words whose group A field is 10 and 11, and it follows a configuration write with a check that every latch is zero, so a design that showed mode 3 or kept stale output data would be reported. Writes and reads with select low must leave the latches and the read data unchanged.

// File: rtl/ppi_pkg.sv
// Shared widths, address codes and command layout for the parallel port
// register interface. Assumes byte-wide ports with a port C split in halves.
package ppi_pkg;
    localparam int PORT_W  = 8;
    localparam int HALF_W  = PORT_W / 2;
    localparam int ADDR_W  = 2;
    localparam int NUM_REG = 1 << ADDR_W;
    localparam int IDX_W   = $clog2(PORT_W);

    typedef enum logic [ADDR_W-1:0] {
        REG_PA  = 2'b00,
        REG_PB  = 2'b01,
        REG_PC  = 2'b10,
        REG_CTL = 2'b11
    } reg_sel_e;

    typedef enum logic [1:0] {
        GMODE_PLAIN   = 2'd0,
        GMODE_STROBED = 2'd1,
        GMODE_BIDIR   = 2'd2
    } grp_mode_e;

    // Bit positions inside the control byte.
    localparam int CMD_KIND_BIT = 7;
    localparam int GA_MODE_HI   = 6;
    localparam int GA_MODE_LO   = 5;
    localparam int PA_DIR_BIT   = 4;
    localparam int PCU_DIR_BIT  = 3;
    localparam int GB_MODE_BIT  = 2;
    localparam int PB_DIR_BIT   = 1;
    localparam int PCL_DIR_BIT  = 0;
    localparam int BSR_IDX_LO   = 1;
    localparam int BSR_VAL_BIT  = 0;

    localparam logic [PORT_W-1:0] CFG_RESET = 8'h9B;
endpackage

// File: rtl/ppi_addr_dec.sv
// Address decoder: turns select, strobes and address into one write enable
// per register plus a qualified read enable. Assumes single-cycle strobes
// sampled on the rising clock edge.
module ppi_addr_dec
    import ppi_pkg::*;
#(
    parameter int AW = ADDR_W,
    localparam int NR = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output logic [NR-1:0] wr_en,
    output logic          rd_en
);
    // One write enable per register, built by a repeated compare.
    for (genvar gi = 0; gi < NR; gi++) begin : g_wsel
        assign wr_en[gi] = sel && wr && (addr == AW'(gi));
    end

    // Read qualified by select.
    assign rd_en = sel && rd;

    p_wr_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (wr_en == '0) && !rd_en);
endmodule

// File: rtl/ppi_ctrl_reg.sv
// Control location: stores configuration words (bit 7 set) and decodes
// single-bit set/reset commands (bit 7 clear) for port C. Assumes the
// write enable lasts a single cycle.
module ppi_ctrl_reg
    import ppi_pkg::*;
#(
    parameter int W = PORT_W,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  cfg_q,
    output logic          cfg_load,
    output logic          bit_en,
    output logic [IW-1:0] bit_idx,
    output logic          bit_val
);
    // Split the command by its kind bit.
    always_comb begin
        cfg_load = wr_en &&  wdata[CMD_KIND_BIT];
        bit_en   = wr_en && !wdata[CMD_KIND_BIT];
        bit_idx  = wdata[BSR_IDX_LO +: IW];
        bit_val  = wdata[BSR_VAL_BIT];
    end

    // Holds the last configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q <= CFG_RESET;
        else if (cfg_load) cfg_q <= wdata;
    end

    p_cfg_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> cfg_q == $past(wdata));
    p_bsr_keeps_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> $stable(cfg_q));
    p_cfg_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[CMD_KIND_BIT]);
endmodule

// File: rtl/ppi_port_latch.sv
// Output latch for one port. Supports a full-byte write, a clear that a
// configuration word triggers, and a single-bit set/reset. Assumes the
// three requests never arrive in the same cycle. If they do, clear wins,
// then write.
module ppi_port_latch #(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    input  logic          bit_en,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    output logic [W-1:0]  q
);
    logic [W-1:0] q_nxt;

    // Per-bit next state.
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        always_comb begin
            if (clr)                                   q_nxt[gi] = 1'b0;
            else if (wr_en)                            q_nxt[gi] = wdata[gi];
            else if (bit_en && bit_idx == IW'(gi))     q_nxt[gi] = bit_val;
            else                                       q_nxt[gi] = q[gi];
        end
    end

    // Latch register.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

    p_clear_on_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> q == '0);
    p_single_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !clr && !wr_en) |=>
            (((q ^ $past(q)) & ~(W'(1) << $past(bit_idx))) == '0)
            && (q[$past(bit_idx)] == $past(bit_val)));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !wr_en && !bit_en) |=> $stable(q));
endmodule

// File: rtl/ppi_read_mux.sv
// Read path: selects the register for the address and, for each half of a
// port, picks the latch when that half drives and the pins when it does
// not. Registers the result on a qualified read.
module ppi_read_mux
    import ppi_pkg::*;
#(
    parameter int W = PORT_W,
    localparam int HW = W / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [W-1:0]        cfg_q,
    input  logic [W-1:0]        pa_q,
    input  logic [W-1:0]        pb_q,
    input  logic [W-1:0]        pc_q,
    input  logic [W-1:0]        pa_pins,
    input  logic [W-1:0]        pb_pins,
    input  logic [W-1:0]        pc_pins,
    input  logic                pa_drive,
    input  logic                pb_drive,
    input  logic [1:0]          pc_drive,
    output logic [W-1:0]        rdata
);
    logic [W-1:0] pa_view, pb_view, pc_view, rd_nxt;

    // Port A and B: one direction for the whole byte.
    assign pa_view = pa_drive ? pa_q : pa_pins;
    assign pb_view = pb_drive ? pb_q : pb_pins;

    // Port C: direction chosen separately per half.
    for (genvar gh = 0; gh < 2; gh++) begin : g_pc_half
        assign pc_view[gh*HW +: HW] = pc_drive[gh] ? pc_q[gh*HW +: HW]
                                                   : pc_pins[gh*HW +: HW];
    end

    // Address select.
    always_comb begin
        unique case (reg_sel_e'(addr))
            REG_PA:  rd_nxt = pa_view;
            REG_PB:  rd_nxt = pb_view;
            REG_PC:  rd_nxt = pc_view;
            default: rd_nxt = cfg_q;
        endcase
    end

    // Read data register.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_nxt;
    end

    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
    p_cfg_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == REG_CTL) |=> rdata == $past(cfg_q));
endmodule

// File: rtl/ppi_regif.sv
// Top of the parallel port register interface. Connects the decoder, the
// control location, three port latches and the read path. It decodes the
// stored configuration word into direction enables and group modes.
// Assumes a synchronous host bus with one-cycle strobes.
module ppi_regif
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        pa_pins,
    input  logic [7:0]        pb_pins,
    input  logic [7:0]        pc_pins,
    output logic [7:0]        pa_out,
    output logic [7:0]        pb_out,
    output logic [7:0]        pc_out,
    output logic              pa_drive,
    output logic              pb_drive,
    output logic              pcu_drive,
    output logic              pcl_drive,
    output logic [1:0]        ga_mode,
    output logic              gb_mode
);
    logic [NUM_REG-1:0] wr_en;
    logic               rd_en;
    logic [PORT_W-1:0]  cfg_q;
    logic               cfg_load;
    logic               bit_en;
    logic [IDX_W-1:0]   bit_idx;
    logic               bit_val;

    ppi_addr_dec #(.AW(ADDR_W)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (bus_sel),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wr_en (wr_en),
        .rd_en (rd_en)
    );

    ppi_ctrl_reg #(.W(PORT_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en[REG_CTL]),
        .wdata    (bus_wdata),
        .cfg_q    (cfg_q),
        .cfg_load (cfg_load),
        .bit_en   (bit_en),
        .bit_idx  (bit_idx),
        .bit_val  (bit_val)
    );

    // Three latches. Only port C accepts single-bit commands.
    logic [PORT_W-1:0] lat_q [3];
    for (genvar gp = 0; gp < 3; gp++) begin : g_port
        ppi_port_latch #(.W(PORT_W)) u_lat (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (cfg_load),
            .wr_en   (wr_en[gp]),
            .wdata   (bus_wdata),
            .bit_en  ((gp == int'(REG_PC)) ? bit_en : 1'b0),
            .bit_idx (bit_idx),
            .bit_val (bit_val),
            .q       (lat_q[gp])
        );
    end

    assign pa_out = lat_q[REG_PA];
    assign pb_out = lat_q[REG_PB];
    assign pc_out = lat_q[REG_PC];

    // Direction and mode decode from the stored word (1 = input).
    always_comb begin
        pa_drive  = !cfg_q[PA_DIR_BIT];
        pb_drive  = !cfg_q[PB_DIR_BIT];
        pcu_drive = !cfg_q[PCU_DIR_BIT];
        pcl_drive = !cfg_q[PCL_DIR_BIT];
        gb_mode   = cfg_q[GB_MODE_BIT];
        if (cfg_q[GA_MODE_HI]) ga_mode = GMODE_BIDIR;
        else if (cfg_q[GA_MODE_LO]) ga_mode = GMODE_STROBED;
        else ga_mode = GMODE_PLAIN;
    end

    ppi_read_mux #(.W(PORT_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .addr     (bus_addr),
        .cfg_q    (cfg_q),
        .pa_q     (lat_q[REG_PA]),
        .pb_q     (lat_q[REG_PB]),
        .pc_q     (lat_q[REG_PC]),
        .pa_pins  (pa_pins),
        .pb_pins  (pb_pins),
        .pc_pins  (pc_pins),
        .pa_drive (pa_drive),
        .pb_drive (pb_drive),
        .pc_drive ({pcu_drive, pcl_drive}),
        .rdata    (bus_rdata)
    );

    p_reset_load_r2: assert property (@(posedge clk)
        !rst_n |=> !pa_drive && !pb_drive && !pcu_drive && !pcl_drive
                   && ga_mode == 2'd0 && !gb_mode
                   && pa_out == '0 && pb_out == '0 && pc_out == '0);
    p_ga_mode_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ga_mode != 2'd3);
    p_unselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out)
                     && $stable(ga_mode) && $stable(bus_rdata));
    p_bsr_dirs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'b11 && !bus_wdata[7]) |=>
            $stable(pa_drive) && $stable(pb_drive) && $stable(pcu_drive)
            && $stable(pcl_drive) && $stable(pa_out) && $stable(pb_out));
endmodule

// File: tb/sim_ppi_regif.sv
// Scoreboard bench: read tasks queue the expected bytes, and a monitor
// pops them and compares each one with the registered read data.
module sim_ppi_regif;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'b00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pa_pins = 8'h00, pb_pins = 8'h00, pc_pins = 8'h00;
    logic [7:0] pa_out, pb_out, pc_out;
    logic       pa_drive, pb_drive, pcu_drive, pcl_drive;
    logic [1:0] ga_mode;
    logic       gb_mode;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #4 clk = ~clk;

    ppi_regif u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pa_pins(pa_pins), .pb_pins(pb_pins),
        .pc_pins(pc_pins), .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
        .pa_drive(pa_drive), .pb_drive(pb_drive), .pcu_drive(pcu_drive),
        .pcl_drive(pcl_drive), .ga_mode(ga_mode), .gb_mode(gb_mode)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    // Marks the edges that carry a qualified read.
    always @(posedge clk) rd_seen <= bus_sel && bus_rd && rst_n;

    // Monitor: compares the read data half a cycle after each read edge.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R8 actual=%02h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset state
        check("R2 drives", {4'h0, pa_drive, pb_drive, pcu_drive, pcl_drive}, 8'h00);
        check("R2 modes", {5'h0, ga_mode, gb_mode}, 8'h00);
        check("R2 latches", pa_out | pb_out | pc_out, 8'h00);
        pa_pins = 8'hA5; pb_pins = 8'h3C; pc_pins = 8'hE7;
        bus_read(2'b11, 8'h9B, "R2 R7 cfg after reset");
        bus_read(2'b00, 8'hA5, "R8 pa pins");
        bus_read(2'b01, 8'h3C, "R8 pb pins");
        bus_read(2'b10, 8'hE7, "R8 pc pins");

        // R3: 98H
        bus_write(2'b11, 8'h98);
        check("R3 98 drives", {4'h0, pa_drive, pb_drive, pcu_drive, pcl_drive}, 8'h05);
        check("R3 98 modes", {5'h0, ga_mode, gb_mode}, 8'h00);
        bus_read(2'b11, 8'h98, "R7 cfg 98");

        // R1: writes land only in the addressed latch
        bus_write(2'b01, 8'h5A);
        check("R1 pb", pb_out, 8'h5A);
        check("R1 pa untouched", pa_out, 8'h00);
        check("R1 pc untouched", pc_out, 8'h00);
        bus_read(2'b01, 8'h5A, "R8 pb latch");
        // R9: write into an input port still updates the latch
        bus_write(2'b00, 8'hFF);
        check("R9 pa latch", pa_out, 8'hFF);
        check("R1 pb kept", pb_out, 8'h5A);
        pa_pins = 8'h11;
        bus_read(2'b00, 8'h11, "R8 pa input returns pins");
        bus_write(2'b10, 8'h3C);
        check("R1 pc", pc_out, 8'h3C);
        bus_read(2'b10, 8'hEC, "R8 pc mixed halves");

        // R6: single-bit commands
        bus_write(2'b11, 8'h0D);
        check("R6 set bit6", pc_out, 8'h7C);
        bus_write(2'b11, 8'h06);
        check("R6 clear bit3", pc_out, 8'h74);
        bus_write(2'b11, 8'h71);
        check("R6 set bit0 upper bits ignored", pc_out, 8'h75);
        check("R6 drives kept", {4'h0, pa_drive, pb_drive, pcu_drive, pcl_drive}, 8'h05);
        check("R6 other latches kept", pa_out ^ pb_out, 8'hA5);
        bus_read(2'b11, 8'h98, "R7 cfg after set/reset");

        // R3 and R5: 92H
        bus_write(2'b11, 8'h92);
        check("R3 92 drives", {4'h0, pa_drive, pb_drive, pcu_drive, pcl_drive}, 8'h03);
        check("R5 pa cleared", pa_out, 8'h00);
        check("R5 pb cleared", pb_out, 8'h00);
        check("R5 pc cleared", pc_out, 8'h00);
        bus_write(2'b10, 8'hA6);
        bus_read(2'b10, 8'hA6, "R8 pc output latch");

        // R4: group modes
        bus_write(2'b11, 8'hC4);
        check("R4 C4 ga", {6'h0, ga_mode}, 8'h02);
        check("R4 C4 gb", {7'h0, gb_mode}, 8'h01);
        check("R3 C4 drives", {4'h0, pa_drive, pb_drive, pcu_drive, pcl_drive}, 8'h0F);
        bus_write(2'b11, 8'hE0);
        check("R4 E0 ga", {6'h0, ga_mode}, 8'h02);
        check("R4 E0 gb", {7'h0, gb_mode}, 8'h00);
        bus_write(2'b11, 8'hA0);
        check("R4 A0 ga", {6'h0, ga_mode}, 8'h01);

        // R10: strobes with select low
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 2'b00; bus_wdata = 8'h99;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R10 pa unchanged", pa_out, 8'h00);
        check("R10 rdata unchanged", bus_rdata, 8'hA6);
        bus_read(2'b11, 8'hA0, "R7 cfg A0");
        bus_write(2'b00, 8'hC3);
        bus_read(2'b00, 8'hC3, "R8 pa output latch");

        repeat (3) @(negedge clk);
        check("R8 scoreboard drained", 8'(exp_q.size()), 8'h00);
        finish_run();
    end
endmodule